// File: doc/BRIEF.md
# Descriptor Validation Checker

This block inspects a 16-word DMA descriptor while it streams past, one 32-bit word per accepted cycle, and delivers a verdict one clock after the final word. It confirms the marker byte in the control word, compares an optional wrapping word sum against the trailing checksum word, and rejects a descriptor that is already flagged complete unless its control word allows reuse. A failed fetch reported by the memory side aborts the descriptor in progress at once.

The verdict is a one-cycle result pulse with either an accept indication or a single error bit, placed at a base position plus the channel number. Alongside it the block returns a packed status word rebuilt from the control fields, a chain-end flag, a write-back request and a completion interrupt bit for the channel. A fetch engine feeds the words and uses these outputs to decide whether to fetch the next descriptor, write back the done flag and raise interrupts.

Top module: `dsc_checker`

## Requirements
- R1: While reset is asserted and until the first result, res_valid, res_ok, err_vec, chain_end, wb_req, irq_vec and stat_word are all zero.
- R2: res_valid is high for exactly one cycle, the cycle after the clock edge that takes the 16th word (index 15) of a descriptor; the channel is sampled with word 0.
- R3: If bits [7:0] of word 0 (control) differ from 0xA5, the result carries err_vec bit (7 + channel) and res_ok low.
- R4: If control bit 20 is set and the modulo 2^32 sum of words 0 to 14 differs from word 15, err_vec bit (13 + channel) is set; with control bit 20 clear, word 15 has no effect on the result.
- R5: If bit 31 of word 5 is set and control bit 10 is clear, err_vec bit (25 + channel) is set; with control bit 10 set the same descriptor is accepted.
- R6: A fetch_err cycle produces a result the next cycle with err_vec bit (1 + chan input), discards the descriptor in progress (a word offered in the same cycle is dropped), leaves stat_word unchanged, and the next word is taken as word 0.
- R7: Only the first failing check is reported, in the order fetch error, marker byte, checksum, done flag.
- R8: On every descriptor result stat_word holds control [7:0] at bits [20:13], control 11 at bit 4, control 18 at bit 5, control 20 at bit 6, control 19 at bit 7, control 21 at bit 8, control 10 at bit 9, word 5 bit 31 at bit 10, control 9 at bit 11, control 8 at bit 12, all other bits zero.
- R9: chain_end accompanies every error result, and an accepted result when control bit 19 or bit 21 is set.
- R10: On an accepted result wb_req equals control bit 9 and irq_vec bit (channel) equals control bit 8; both are zero on an error result.
- R11: Cycles with word_valid low neither advance the word position nor alter the running sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | A descriptor word is offered this cycle |
| word_data | input | 32 | Descriptor word |
| fetch_err | input | 1 | Descriptor fetch failed; abort |
| chan | input | 3 | Channel number |
| res_valid | output | 1 | One-cycle result pulse |
| res_ok | output | 1 | Descriptor accepted |
| err_vec | output | 32 | One-hot error bit, zero on accept |
| stat_word | output | 32 | Packed status rebuilt from the descriptor |
| chain_end | output | 1 | No further descriptor should be fetched |
| wb_req | output | 1 | Write the descriptor back with the done flag set |
| irq_vec | output | 32 | Completion interrupt bit for the channel |

## Verification
The two functions that can share a cycle are the abort on a fetch error and the evaluation of the final checksum word. The bench raises fetch_err in the very cycle word 15 is offered, then expects one result carrying only the fetch error bit, no second pulse in the following cycle, an unchanged status word, and a clean accept for the next full descriptor. A milder form, an abort after seven words, confirms the word position restarts at zero.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 16;
    localparam int CH_W    = 3;

    localparam logic [7:0] MARKER = 8'hA5;

    // Error bit bases (result bit = base + channel)
    localparam int EB_FETCH  = 1;
    localparam int EB_MARKER = 7;
    localparam int EB_SUM    = 13;
    localparam int EB_DONE   = 25;

    localparam int DONE_WORD = 5;
    localparam int DONE_BIT  = 31;

    // Control word fields
    localparam int CF_IRQ    = 8;
    localparam int CF_WB     = 9;
    localparam int CF_IGNORE = 10;
    localparam int CF_LAST   = 19;
    localparam int CF_SUMEN  = 20;
    localparam int CF_LOF    = 21;

    // Status word layout
    localparam int N_MAP         = 8;
    localparam int MAP_CTRL [N_MAP] = '{11, 18, 20, 19, 21, 10, 9, 8};
    localparam int MAP_STAT [N_MAP] = '{4, 5, 6, 7, 8, 9, 11, 12};
    localparam int ST_DONE       = 10;
    localparam int ST_MARK_LSB   = 13;
endpackage

// File: rtl/dsc_word_ctr.sv
module dsc_word_ctr #(
    parameter int N_WORDS = dsc_pkg::N_WORDS,
    localparam int IDX_W  = $clog2(N_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             is_first,
    output logic             is_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr)
            idx_d = '0;
        else if (adv)
            idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx      = idx_q;
    assign is_first = (idx_q == '0);
    assign is_last  = (idx_q == LAST_IDX);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(idx));
endmodule

// File: rtl/dsc_csum.sv
module dsc_csum #(
    parameter int WORD_W = dsc_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc,
    input  logic              first,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] sum
);
    logic [WORD_W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr)
            sum_d = '0;
        else if (acc)
            sum_d = first ? data : sum_q + data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;

    // R4
    sum_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && first && !clr) |=> (sum == $past(data)));
endmodule

// File: rtl/dsc_stat_build.sv
module dsc_stat_build #(
    parameter int WORD_W = dsc_pkg::WORD_W
) (
    input  logic [WORD_W-1:0] ctrl,
    input  logic              done,
    output logic [WORD_W-1:0] stat
);
    import dsc_pkg::*;

    logic [N_MAP-1:0] flag;

    genvar g;
    generate
        for (g = 0; g < N_MAP; g++) begin : g_map
            assign flag[g] = ctrl[MAP_CTRL[g]];
        end
    endgenerate

    always_comb begin
        stat = '0;
        for (int i = 0; i < N_MAP; i++)
            stat[MAP_STAT[i]] = flag[i];
        stat[ST_DONE]          = done;
        stat[ST_MARK_LSB +: 8] = ctrl[7:0];
    end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int WORD_W  = dsc_pkg::WORD_W,
    parameter int N_WORDS = dsc_pkg::N_WORDS,
    parameter int CH_W    = dsc_pkg::CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              fetch_err,
    input  logic [CH_W-1:0]   chan,
    output logic              res_valid,
    output logic              res_ok,
    output logic [WORD_W-1:0] err_vec,
    output logic [WORD_W-1:0] stat_word,
    output logic              chain_end,
    output logic              wb_req,
    output logic [WORD_W-1:0] irq_vec
);
    import dsc_pkg::*;

    localparam int IDX_W = $clog2(N_WORDS);
    localparam logic [IDX_W-1:0] DONE_IDX = IDX_W'(DONE_WORD);

    typedef struct packed {
        logic              res_valid;
        logic              res_ok;
        logic [WORD_W-1:0] err_vec;
        logic [WORD_W-1:0] stat;
        logic              chain_end;
        logic              wb_req;
        logic [WORD_W-1:0] irq_vec;
        logic [WORD_W-1:0] ctrl;
        logic              done_flag;
        logic [CH_W-1:0]   chan;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0]  idx;
    logic              is_first, is_last;
    logic              adv;
    logic [WORD_W-1:0] run_sum;
    logic [WORD_W-1:0] stat_new;

    function automatic logic [WORD_W-1:0] one_at(input int pos);
        return {{(WORD_W-1){1'b0}}, 1'b1} << pos;
    endfunction

    assign adv = word_valid && !fetch_err;

    dsc_word_ctr #(.N_WORDS(N_WORDS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fetch_err),
        .adv      (adv),
        .idx      (idx),
        .is_first (is_first),
        .is_last  (is_last)
    );

    dsc_csum #(.WORD_W(WORD_W)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fetch_err),
        .acc   (adv && !is_last),
        .first (is_first),
        .data  (word_data),
        .sum   (run_sum)
    );

    dsc_stat_build #(.WORD_W(WORD_W)) u_stat (
        .ctrl (st_q.ctrl),
        .done (st_q.done_flag),
        .stat (stat_new)
    );

    always_comb begin
        logic marker_bad, sum_bad, done_bad, accept;
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        st_d.res_ok    = 1'b0;
        st_d.err_vec   = '0;
        st_d.chain_end = 1'b0;
        st_d.wb_req    = 1'b0;
        st_d.irq_vec   = '0;

        marker_bad = (st_q.ctrl[7:0] != MARKER);
        sum_bad    = st_q.ctrl[CF_SUMEN] && (run_sum != word_data);
        done_bad   = st_q.done_flag && !st_q.ctrl[CF_IGNORE];
        accept     = !marker_bad && !sum_bad && !done_bad;

        if (fetch_err) begin
            st_d.res_valid = 1'b1;
            st_d.err_vec   = one_at(EB_FETCH + int'(chan));
            st_d.chain_end = 1'b1;
        end else if (word_valid) begin
            if (is_first) begin
                st_d.ctrl      = word_data;
                st_d.chan      = chan;
                st_d.done_flag = 1'b0;
            end
            if (idx == DONE_IDX)
                st_d.done_flag = word_data[DONE_BIT];
            if (is_last) begin
                st_d.res_valid = 1'b1;
                st_d.stat      = stat_new;
                if (marker_bad)
                    st_d.err_vec = one_at(EB_MARKER + int'(st_q.chan));
                else if (sum_bad)
                    st_d.err_vec = one_at(EB_SUM + int'(st_q.chan));
                else if (done_bad)
                    st_d.err_vec = one_at(EB_DONE + int'(st_q.chan));
                st_d.res_ok    = accept;
                st_d.chain_end = !accept || st_q.ctrl[CF_LAST] || st_q.ctrl[CF_LOF];
                st_d.wb_req    = accept && st_q.ctrl[CF_WB];
                if (accept && st_q.ctrl[CF_IRQ])
                    st_d.irq_vec = one_at(int'(st_q.chan));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.res_valid;
    assign res_ok    = st_q.res_ok;
    assign err_vec   = st_q.err_vec;
    assign stat_word = st_q.stat;
    assign chain_end = st_q.chain_end;
    assign wb_req    = st_q.wb_req;
    assign irq_vec   = st_q.irq_vec;

    // R7
    err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_vec));
    // R2
    ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_ok |-> (res_valid && err_vec == '0));
    // R6
    fetch_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |=> (res_valid && !res_ok && err_vec != '0));
    // R9
    err_ends_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ok) |-> chain_end);
    // R10
    wb_only_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req || irq_vec != '0) |-> res_ok);
    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_vec) <= 1);
endmodule

// File: tb/tb_dsc_checker.sv
module tb_dsc_checker;
    localparam int CLK_P = 10;
    localparam int NV    = 9;

    localparam logic [31:0] T_CTRL [NV] = '{
        32'h0008_03A5, 32'h0010_00A5, 32'h0010_00A5, 32'h0000_005A, 32'h0000_00A5,
        32'h0020_04A5, 32'h0010_0000, 32'h0010_00A5, 32'h0004_09A5};
    localparam bit T_DONE  [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 0};
    localparam bit T_SUMOK [NV] = '{1, 1, 0, 1, 1, 1, 0, 0, 0};
    localparam int T_CH    [NV] = '{0, 2, 3, 1, 4, 5, 5, 0, 1};
    localparam bit T_GAP   [NV] = '{0, 0, 1, 0, 0, 0, 0, 1, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        fetch_err = 1'b0;
    logic [2:0]  chan = '0;
    logic        res_valid, res_ok, chain_end, wb_req;
    logic [31:0] err_vec, stat_word, irq_vec;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] last_stat = '0;

    always #(CLK_P/2) clk = ~clk;

    dsc_checker dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .fetch_err(fetch_err), .chan(chan), .res_valid(res_valid), .res_ok(res_ok),
        .err_vec(err_vec), .stat_word(stat_word), .chain_end(chain_end),
        .wb_req(wb_req), .irq_vec(irq_vec));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_err(input logic [31:0] c, input bit dn,
                                            input bit sok, input int ch);
        if (c[7:0] != 8'hA5)       return 32'd1 << (7 + ch);
        if (c[20] && !sok)         return 32'd1 << (13 + ch);
        if (dn && !c[10])          return 32'd1 << (25 + ch);
        return '0;
    endfunction

    function automatic logic [31:0] exp_stat(input logic [31:0] c, input bit dn);
        logic [31:0] s = '0;
        s[20:13] = c[7:0];
        s[4] = c[11]; s[5] = c[18]; s[6] = c[20]; s[7] = c[19];
        s[8] = c[21]; s[9] = c[10]; s[10] = dn;   s[11] = c[9];
        s[12] = c[8];
        return s;
    endfunction

    // Streams one descriptor; abort_at >= 0 raises fetch_err on that word.
    task automatic send_desc(input logic [31:0] c, input bit dn, input bit sok,
                             input int ch, input bit gap, input int abort_at);
        logic [31:0] w [16];
        logic [31:0] sum = '0;
        w[0] = c;
        for (int k = 1; k < 15; k++) w[k] = (32'h1357_9BDF * k) ^ c;
        w[5] = dn ? (w[5] | 32'h8000_0000) : (w[5] & 32'h7FFF_FFFF);
        for (int k = 0; k < 15; k++) sum = sum + w[k];
        w[15] = sok ? sum : (sum ^ 32'h0000_0001);
        for (int k = 0; k < 16; k++) begin
            if (gap && (k == 3 || k == 7 || k == 15)) begin
                @(negedge clk);
                word_valid = 1'b0;
                word_data  = 32'hDEAD_BEEF;  // R11 idle data must not count
                @(negedge clk);
                // R11 no premature result during idle cycles
                check("R11 no result in gap", {31'd0, res_valid}, 32'd0);
            end else begin
                @(negedge clk);
            end
            word_valid = 1'b1;
            word_data  = w[k];
            chan       = 3'(ch);
            if (k == abort_at) begin
                fetch_err = 1'b1;
                break;
            end
        end
        @(negedge clk);
        word_valid = 1'b0;
        fetch_err  = 1'b0;
    endtask

    task automatic check_result(input logic [31:0] c, input bit dn, input bit sok, input int ch);
        logic [31:0] e  = exp_err(c, dn, sok, ch);
        bit          ok = (e == '0);
        check("R2 res_valid", {31'd0, res_valid}, 32'd1);
        check("R3 R4 R5 R7 err_vec", err_vec, e);
        check("R3 R4 R5 res_ok", {31'd0, res_ok}, {31'd0, ok});
        check("R8 stat_word", stat_word, exp_stat(c, dn));
        check("R9 chain_end", {31'd0, chain_end}, {31'd0, (!ok || c[19] || c[21])});
        check("R10 wb_req", {31'd0, wb_req}, {31'd0, (ok && c[9])});
        check("R10 irq_vec", irq_vec, (ok && c[8]) ? (32'd1 << ch) : 32'd0);
        last_stat = exp_stat(c, dn);
        @(negedge clk);
        check("R2 single pulse", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 res_valid", {31'd0, res_valid}, 32'd0);
        check("R1 err_vec", err_vec, 32'd0);
        check("R1 stat_word", stat_word, 32'd0);
        check("R1 flags", {28'd0, res_ok, chain_end, wb_req, 1'b0}, 32'd0);
        check("R1 irq_vec", irq_vec, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {31'd0, res_valid}, 32'd0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            send_desc(T_CTRL[v], T_DONE[v], T_SUMOK[v], T_CH[v], T_GAP[v], -1);
            check_result(T_CTRL[v], T_DONE[v], T_SUMOK[v], T_CH[v]);
        end

        // R6 fetch error alone
        @(negedge clk);
        chan = 3'd3;
        fetch_err = 1'b1;
        @(negedge clk);
        fetch_err = 1'b0;
        check("R6 fetch res_valid", {31'd0, res_valid}, 32'd1);
        check("R6 fetch err_vec", err_vec, 32'd1 << 4);
        check("R6 fetch res_ok", {31'd0, res_ok}, 32'd0);
        check("R6 R9 fetch chain_end", {31'd0, chain_end}, 32'd1);
        check("R6 stat unchanged", stat_word, last_stat);

        // R6 abort mid-descriptor, then a clean descriptor restarts at word 0
        send_desc(32'h0000_01A5, 0, 1, 2, 0, 7);
        check("R6 mid abort err_vec", err_vec, 32'd1 << 3);
        send_desc(32'h0000_01A5, 0, 1, 2, 0, -1);
        check_result(32'h0000_01A5, 0, 1, 2);

        // R6 R7 fetch error coincides with the final word
        send_desc(32'h0010_03A5, 0, 1, 4, 0, 15);
        check("R6 R7 same-cycle err_vec", err_vec, 32'd1 << 5);
        check("R6 same-cycle wb_req", {31'd0, wb_req}, 32'd0);
        check("R6 same-cycle stat", stat_word, last_stat);
        @(negedge clk);
        check("R6 no late result", {31'd0, res_valid}, 32'd0);
        send_desc(32'h0010_03A5, 0, 1, 4, 0, -1);
        check_result(32'h0010_03A5, 0, 1, 4);

        finish_run();
    end
endmodule